// File: doc/BRIEF.md
# Partitioned Recency Victim Selector

This block tracks how recently each of a cache's sectors has been referenced by instruction or operand fetches and names the sector that should be given up when a new main-storage sector has to be brought in. The sectors can be split into a power-of-two number of equal groups. Each group keeps its own recency order. The low-order bits of the incoming main-storage sector address pick the group, and the victim is the least recently referenced sector of that group. A one-group setting gives a fully associative choice, and a one-sector-per-group setting gives a direct-mapped choice.

The surrounding cache control pulses a touch strobe with the index of each sector it hits or fills. It also marks whether the reference is a store. A store never reorders anything. A victim query is simply the low sector-address bits on `query_sec_lo_i`. The answer appears combinationally on `victim_idx_o`. The grouping is a static setting on `part_log2_i`. Tag storage, validity bits and data paths belong to the host.

Top module: `sector_victim_sel`

## Requirements
- R1: After reset, or while reset is held, the victim of every group is its highest-numbered sector. Within each group a lower sector number counts as more recent. A touch presented during reset is discarded.
- R2: A fetch touch (`touch_valid_i`=1, `touch_store_i`=0) makes the touched sector the most recent one. Every sector that was more recent moves down one place. Sectors that were less recent keep their relative order.
- R3: The victim is the least recently touched sector among the members of the selected group.
- R4: `part_log2_i`=n selects 2^n groups, where n is 0..4. Group k holds sectors k*S to k*S+S-1, with S=16/2^n. The group number is the low n bits of `query_sec_lo_i`. Values 5..7 act as 4.
- R5: With n=0 the selector is one least-recently-used order over all 16 sectors.
- R6: With n=4 the victim equals `query_sec_lo_i`.
- R7: A store touch (`touch_store_i`=1) leaves the ordering unchanged.
- R8: `victim_idx_o` is combinational from the current state. A query in the same cycle as a touch sees the order from before that touch.
- R9: All groups derive from one shared recency history. After a change of `part_log2_i`, each group's order is the order of its members' most recent fetch touches, with no reset needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| touch_valid_i | input | 1 | A reference to a sector this cycle |
| touch_store_i | input | 1 | The reference is a store (no reorder) |
| touch_idx_i | input | 4 | Sector referenced |
| part_log2_i | input | 3 | log2 of the group count (static) |
| query_sec_lo_i | input | 4 | Low bits of the main-storage sector address being placed |
| victim_idx_o | output | 4 | Sector chosen for reassignment |

## Verification
The two functions that can fall in one cycle are a fetch touch and a victim query. The case that matters most is a touch of the very sector the query would name. The bench provokes this in its vector table by touching the current victim while querying the same group. Its random phase does the same often, with queries in every group setting. It judges the answer against an in-bench recency list, which is updated only after the sample. The expected victim is therefore always the pre-touch one. The checker also requires that a touched sector is no longer the victim of its group in the next cycle.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  function automatic int unsigned clamp_plog(input int unsigned req, input int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction
endpackage

// File: rtl/vsel_part_dec.sv
module vsel_part_dec #(
  parameter int unsigned NUM_SECTORS = 16,
  parameter int unsigned MODE_W      = 3,
  localparam int unsigned IDX_W      = $clog2(NUM_SECTORS)
) (
  input  logic [MODE_W-1:0]      part_log2_i,
  input  logic [IDX_W-1:0]       query_sec_lo_i,
  output logic [NUM_SECTORS-1:0] member_o
);
  int unsigned     pl;
  int unsigned     grp;
  logic [IDX_W-1:0] qmask;
  logic [IDX_W-1:0] qpart;

  always_comb begin
    pl  = vsel_pkg::clamp_plog(int'(part_log2_i), IDX_W);
    grp = IDX_W - pl;
    for (int b = 0; b < IDX_W; b++) qmask[b] = (b < int'(pl));
    qpart = query_sec_lo_i & qmask;
    for (int s = 0; s < NUM_SECTORS; s++)
      member_o[s] = ((IDX_W'(s) >> grp) == qpart);
  end
endmodule

// File: rtl/vsel_age_matrix.sv
// Pairwise recency: newer_o[i][j] = sector i referenced more recently than j.
module vsel_age_matrix #(
  parameter int unsigned NUM_SECTORS = 16,
  localparam int unsigned IDX_W      = $clog2(NUM_SECTORS)
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      upd_i,
  input  logic [IDX_W-1:0]                          upd_idx_i,
  output logic [NUM_SECTORS-1:0][NUM_SECTORS-1:0]   newer_o
);
  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_row
    for (genvar j = 0; j < NUM_SECTORS; j++) begin : g_col
      if (i < j) begin : g_pair
        logic bit_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) bit_q <= 1'b1;
          else if (upd_i) begin
            if (upd_idx_i == IDX_W'(i))      bit_q <= 1'b1;
            else if (upd_idx_i == IDX_W'(j)) bit_q <= 1'b0;
          end
        end
        assign newer_o[i][j] = bit_q;
        assign newer_o[j][i] = ~bit_q;
      end else if (i == j) begin : g_diag
        assign newer_o[i][j] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/vsel_pick.sv
// Victim = the member that every other member beats on recency.
module vsel_pick #(
  parameter int unsigned NUM_SECTORS = 16,
  localparam int unsigned IDX_W      = $clog2(NUM_SECTORS)
) (
  input  logic [NUM_SECTORS-1:0][NUM_SECTORS-1:0] newer_i,
  input  logic [NUM_SECTORS-1:0]                  member_i,
  output logic [IDX_W-1:0]                        victim_o
);
  logic [NUM_SECTORS-1:0] cand;

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_cand
    logic [NUM_SECTORS-1:0] beaten;
    for (genvar j = 0; j < NUM_SECTORS; j++) begin : g_by
      if (j == s) begin : g_self
        assign beaten[j] = 1'b1;
      end else begin : g_other
        assign beaten[j] = newer_i[j][s] | ~member_i[j];
      end
    end
    assign cand[s] = member_i[s] & (&beaten);
  end

  always_comb begin
    victim_o = '0;
    for (int s = 0; s < NUM_SECTORS; s++)
      if (cand[s]) victim_o = victim_o | IDX_W'(s);
  end
endmodule

// File: rtl/sector_victim_sel.sv
module sector_victim_sel #(
  parameter int unsigned NUM_SECTORS = 16,
  localparam int unsigned IDX_W      = $clog2(NUM_SECTORS),
  localparam int unsigned MODE_W     = $clog2(IDX_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              touch_valid_i,
  input  logic              touch_store_i,
  input  logic [IDX_W-1:0]  touch_idx_i,
  input  logic [MODE_W-1:0] part_log2_i,
  input  logic [IDX_W-1:0]  query_sec_lo_i,
  output logic [IDX_W-1:0]  victim_idx_o
);
  logic [NUM_SECTORS-1:0][NUM_SECTORS-1:0] newer;
  logic [NUM_SECTORS-1:0]                  member;
  logic                                    fetch_touch;

  assign fetch_touch = touch_valid_i & ~touch_store_i;

  vsel_age_matrix #(.NUM_SECTORS(NUM_SECTORS)) u_age (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (fetch_touch),
    .upd_idx_i(touch_idx_i),
    .newer_o  (newer)
  );

  vsel_part_dec #(.NUM_SECTORS(NUM_SECTORS), .MODE_W(MODE_W)) u_dec (
    .part_log2_i   (part_log2_i),
    .query_sec_lo_i(query_sec_lo_i),
    .member_o      (member)
  );

  vsel_pick #(.NUM_SECTORS(NUM_SECTORS)) u_pick (
    .newer_i (newer),
    .member_i(member),
    .victim_o(victim_idx_o)
  );
endmodule

// File: rtl/sector_victim_sel_chk.sv
module sector_victim_sel_chk #(
  parameter int unsigned NUM_SECTORS = 16,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned MODE_W      = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              touch_valid_i,
  input logic              touch_store_i,
  input logic [IDX_W-1:0]  touch_idx_i,
  input logic [MODE_W-1:0] part_log2_i,
  input logic [IDX_W-1:0]  query_sec_lo_i,
  input logic [IDX_W-1:0]  victim_idx_o
);
  logic [MODE_W-1:0] plog, grp;
  logic [IDX_W-1:0]  qmask, qpart, vpart, tpart;

  always_comb begin
    plog = (part_log2_i > MODE_W'(IDX_W)) ? MODE_W'(IDX_W) : part_log2_i;
    grp  = MODE_W'(IDX_W) - plog;
    for (int b = 0; b < IDX_W; b++) qmask[b] = (MODE_W'(b) < plog);
    qpart = query_sec_lo_i & qmask;
    vpart = victim_idx_o >> grp;
    tpart = touch_idx_i >> grp;
  end

  a_r4_victim_in_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpart == qpart);

  a_r6_direct_mapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plog == MODE_W'(IDX_W)) |-> (victim_idx_o == query_sec_lo_i));

  a_r7_store_no_reorder: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!touch_valid_i || touch_store_i) && $stable(part_log2_i) && $stable(query_sec_lo_i))
      |-> $stable(victim_idx_o));

  a_r2_touched_not_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(touch_valid_i && !touch_store_i) && $stable(part_log2_i)
      && (plog != MODE_W'(IDX_W)) && ($past(tpart) == qpart))
      |-> (victim_idx_o != $past(touch_idx_i)));

  a_r8_victim_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(victim_idx_o));
endmodule

bind sector_victim_sel sector_victim_sel_chk #(
  .NUM_SECTORS(NUM_SECTORS), .IDX_W(IDX_W), .MODE_W(MODE_W)
) u_chk (.*);

// File: tb/tb_sector_victim_sel.sv
`timescale 1ns/1ps
module tb_sector_victim_sel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       touch_valid_i = 1'b0;
  logic       touch_store_i = 1'b0;
  logic [3:0] touch_idx_i = '0;
  logic [2:0] part_log2_i = '0;
  logic [3:0] query_sec_lo_i = '0;
  logic [3:0] victim_idx_o;

  int tests = 0;
  int fails = 0;
  int ord[16];
  logic [31:0] lfsr = 32'h1badf00d;

  always #4 clk_i = ~clk_i;

  sector_victim_sel dut (.*);

  // {touch_valid, store, touch_idx, part_log2, query, expected victim}
  localparam int NV = 15;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd0,  3'd0, 4'd0, 4'd15},  // R1 reset victim
    {1'b1, 1'b0, 4'd15, 3'd0, 4'd0, 4'd15},  // R8 touch of victim, old answer
    {1'b0, 1'b0, 4'd0,  3'd0, 4'd0, 4'd14},  // R2
    {1'b1, 1'b1, 4'd14, 3'd0, 4'd0, 4'd14},  // R7 store
    {1'b0, 1'b0, 4'd0,  3'd0, 4'd0, 4'd14},  // R7 unchanged
    {1'b1, 1'b0, 4'd14, 3'd0, 4'd0, 4'd14},
    {1'b0, 1'b0, 4'd0,  3'd0, 4'd0, 4'd13},  // R5
    {1'b0, 1'b0, 4'd0,  3'd2, 4'd3, 4'd13},  // R4 group 3 of 4
    {1'b0, 1'b0, 4'd0,  3'd2, 4'd1, 4'd7},
    {1'b0, 1'b0, 4'd0,  3'd4, 4'd5, 4'd5},   // R6
    {1'b0, 1'b0, 4'd0,  3'd1, 4'd1, 4'd13},  // R9
    {1'b0, 1'b0, 4'd0,  3'd1, 4'd0, 4'd7},
    {1'b1, 1'b0, 4'd15, 3'd3, 4'd7, 4'd15},  // R8
    {1'b0, 1'b0, 4'd0,  3'd3, 4'd7, 4'd14},  // R3
    {1'b0, 1'b0, 4'd0,  3'd5, 4'd9, 4'd9}    // R4 clamp
  };

  task automatic check(input int act, input int exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: victim actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) ord[i] = i;
  endtask

  task automatic model_touch(input int s);
    int pos = 0;
    for (int i = 0; i < 16; i++) if (ord[i] == s) pos = i;
    for (int i = pos; i > 0; i--) ord[i] = ord[i-1];
    ord[0] = s;
  endtask

  function automatic int model_victim(input int mode, input int q);
    int pl  = (mode > 4) ? 4 : mode;
    int grp = 4 - pl;
    int prt = q & ((1 << pl) - 1);
    for (int p = 15; p >= 0; p--) if ((ord[p] >> grp) == prt) return ord[p];
    return -1;
  endfunction

  task automatic step(input bit tv, input bit st, input int idx, input int mode,
                      input int q, input int exp, input string req);
    @(negedge clk_i);
    touch_valid_i  = tv;
    touch_store_i  = st;
    touch_idx_i    = 4'(idx);
    part_log2_i    = 3'(mode);
    query_sec_lo_i = 4'(q);
    #1;
    check(int'(victim_idx_o), exp, req);
    if (tv && !st) model_touch(idx);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++)
      step(VEC[v][16], VEC[v][15], int'(VEC[v][14:11]), int'(VEC[v][10:8]),
           int'(VEC[v][7:4]), int'(VEC[v][3:0]), $sformatf("R3 vector %0d", v));

    // R9 / R3 / R8: mixed groupings against the list model
    for (int n = 0; n < 3000; n++) begin
      int mode, q, idx;
      bit tv, st;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      mode = int'(lfsr[2:0]) % 6;
      q    = int'(lfsr[7:4]);
      idx  = int'(lfsr[11:8]);
      tv   = lfsr[12] | lfsr[13];
      st   = lfsr[14] & lfsr[15];
      step(tv, st, idx, mode, q, model_victim(mode, q), "R9 random");
    end

    // R1: asynchronous reset with a touch held during it
    @(negedge clk_i);
    rst_ni = 1'b0;
    touch_valid_i = 1'b1; touch_store_i = 1'b0; touch_idx_i = 4'd15;
    part_log2_i = 3'd0; query_sec_lo_i = 4'd0;
    #2;
    check(int'(victim_idx_o), 15, "R1 async reset");
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    touch_valid_i = 1'b0;
    model_reset();
    for (int m = 0; m < 5; m++)
      for (int k = 0; k < (1 << m); k++)
        step(1'b0, 1'b0, 0, m, k, (k + 1) * (16 >> m) - 1, "R1 reset order");

    // R6: direct mapped after touches
    step(1'b1, 1'b0, 3, 4, 3, 3, "R6 touch own group");
    step(1'b0, 1'b0, 0, 4, 3, 3, "R6 still direct");
    // R7: store to the victim of a 2-sector group
    step(1'b1, 1'b1, 1, 3, 0, 1, "R7 store on victim");
    step(1'b0, 1'b0, 0, 3, 0, 1, "R7 victim kept");

    @(negedge clk_i);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule